// File: doc/BRIEF.md
# Systolic CIOS Montgomery Modular Multiplier

This block returns the Montgomery product x·y·2^-K mod p of two K-bit operands. The operands are cut into NUM_WORDS words of WORD_W bits, so K = WORD_W·NUM_WORDS. The default is 8 words of 32 bits, which gives K = 256. The block uses the coarsely integrated operand scanning form. Each outer pass over one word of x first accumulates x[i]·y into a running sum. The same pass then adds a multiple m·p that clears the low word, and the sum shifts down by one word. The full double-width product is never built.

A fixed bank of ceil(NUM_WORDS/3) multiply-accumulate cells and the same number of reduction cells handles each outer pass. A three-phase controller reuses this bank in phases 0, 1 and 2. In each phase the bank works on one group of consecutive words, and carries pass from one phase to the next in registers. In phase 0 a word-level cell derives the reduction factor m from the low sum word and the constant m' = -p^-1 mod 2^WORD_W. At the end of phase 2 two add-only tail cells fold both carries into the top of the sum. The schedule always runs NUM_WORDS+3 rounds of three phases. It finishes with one conditional subtraction of p. The caller converts values into and out of the Montgomery domain and supplies m'.

Top module: `mont_cios_mul`

## Requirements
- R1: For odd p, x < p and y < p, the result is x·y·2^-K mod p. This includes x = 0, which gives 0, and y = 1.
- R2: Every result presented with done is strictly below p, including when x = y = p-1.
- R3: done goes high exactly 3·(NUM_WORDS+3) clock cycles after the rising edge that accepts start. This is 33 cycles for 8 words.
- R4: done is high for exactly one cycle per accepted operation.
- R5: product keeps its value from the cycle done is high until the next operation completes, whatever the operand inputs do in between.
- R6: A start while an operation is in progress is ignored. The running operation completes on its own schedule with the operands sampled when it was accepted.
- R7: An active-high synchronous reset clears product to 0 and done to 0, and abandons any operation in progress, so no done follows.
- R8: When x = 2^K mod p, the result equals y. This is the identity element of the Montgomery domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_x | input | K | First operand, word 0 in the low bits |
| op_y | input | K | Second operand |
| modulus | input | K | Odd modulus p |
| m_prime | input | WORD_W | -p^-1 mod 2^WORD_W |
| done | output | 1 | One-cycle completion pulse |
| product | output | K | Montgomery product, held between operations |

## Verification
A corrupted inter-phase carry, a stale reduction factor or a word fed to the wrong cell inside the bank does not show at the ports while the operation runs. It appears as a wrong product or as a value at or above p at the single done cycle, 3·(NUM_WORDS+3) cycles after start. A controller that miscounts rounds or phases shows as done arriving on a different cycle, or as done with no matching start. A register overwritten while idle shows as product changing between operations. Comparing against a bit-serial reference over many moduli makes a missing carry show up within one operation.

// File: rtl/mont_cios_mul.sv
module mont_cios_mul #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [WORD_W*NUM_WORDS-1:0]   op_x,
  input  logic [WORD_W*NUM_WORDS-1:0]   op_y,
  input  logic [WORD_W*NUM_WORDS-1:0]   modulus,
  input  logic [WORD_W-1:0]             m_prime,
  output logic                          done,
  output logic [WORD_W*NUM_WORDS-1:0]   product
);
  localparam int W  = WORD_W;
  localparam int S  = NUM_WORDS;
  localparam int K  = W * S;
  localparam int G  = (S + 2) / 3;
  localparam int RW = $clog2(S + 3);

  logic                 busy;
  logic [1:0]           st;
  logic [RW-1:0]        rnd;
  logic [K-1:0]         x_q;
  logic [S-1:0][W-1:0]  y_q, p_q, t_q, t_nx;
  logic                 t_top, top_nx;
  logic [W-1:0]         mp_q, m_q, ca_q, cg_q, ac, gc, m_now;
  logic [W-1:0]         xw, u0w, beta;
  logic [K:0]           vt;
  logic [K-1:0]         fin;

  assign xw   = x_q[W-1:0];
  assign u0w  = t_q[0] + xw * y_q[0];
  assign beta = u0w * mp_q;
  assign m_now = (st == 2'd0) ? beta : m_q;

  always_comb begin
    int j;
    logic [2*W-1:0] u, v;
    logic [W:0]     z;
    ac     = (st == 2'd0) ? '0 : ca_q;
    gc     = (st == 2'd0) ? '0 : cg_q;
    t_nx   = t_q;
    top_nx = t_top;
    u = '0;
    v = '0;
    for (int c = 0; c < G; c++) begin
      j = int'(st) * G + c;
      if (j < S) begin
        u  = {{W{1'b0}}, t_q[j]} + {{W{1'b0}}, xw} * {{W{1'b0}}, y_q[j]} + {{W{1'b0}}, ac};
        ac = u[2*W-1:W];
        v  = {{W{1'b0}}, m_now} * {{W{1'b0}}, p_q[j]} + {{W{1'b0}}, u[W-1:0]} + {{W{1'b0}}, gc};
        gc = v[2*W-1:W];
        if (j > 0) t_nx[j-1] = v[W-1:0];
      end
    end
    z = {{W{1'b0}}, t_top} + {1'b0, ac} + {1'b0, gc};
    if (st == 2'd2) begin
      t_nx[S-1] = z[W-1:0];
      top_nx    = z[W];
    end
  end

  assign vt  = {t_top, t_q};
  assign fin = (vt >= {1'b0, p_q}) ? K'(vt - {1'b0, p_q}) : vt[K-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; st <= '0; rnd <= '0; done <= 1'b0; product <= '0;
      x_q <= '0; y_q <= '0; p_q <= '0; t_q <= '0; t_top <= 1'b0;
      mp_q <= '0; m_q <= '0; ca_q <= '0; cg_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; st <= '0; rnd <= '0;
          x_q <= op_x; y_q <= op_y; p_q <= modulus; mp_q <= m_prime;
          t_q <= '0; t_top <= 1'b0; ca_q <= '0; cg_q <= '0;
        end
      end else begin
        if (rnd < RW'(S)) begin
          t_q <= t_nx; t_top <= top_nx; ca_q <= ac; cg_q <= gc;
          if (st == 2'd0) m_q <= m_now;
        end
        if (st == 2'd2) begin
          st  <= '0;
          rnd <= rnd + 1'b1;
          x_q <= {x_q[W-1:0], x_q[K-1:W]};
          if (rnd == RW'(S + 2)) begin
            busy <= 1'b0; done <= 1'b1; product <= fin;
          end
        end else begin
          st <= st + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mont_cios_mul_chk.sv
module mont_cios_mul_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic [WORD_W*NUM_WORDS-1:0] product,
  input logic [WORD_W*NUM_WORDS-1:0] mod_q
);
  localparam int N = 3 * (NUM_WORDS + 3);
  logic [15:0] lat;

  always_ff @(posedge clk) begin
    if (rst) lat <= '0;
    else if (busy) lat <= lat + 16'd1;
    else if (start) lat <= '0;
  end

  AST_RESULT_BELOW_P: assert property (@(posedge clk) disable iff (rst) done |-> product < mod_q); // R2
  AST_FIXED_LATENCY:  assert property (@(posedge clk) disable iff (rst) done |-> lat == 16'(N)); // R3
  AST_DONE_PULSE:     assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_PRODUCT_HOLD:   assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(product)); // R5
  AST_START_IGNORED:  assert property (@(posedge clk) disable iff (rst) busy |=> $stable(mod_q)); // R6
  AST_RESET_CLEARS:   assert property (@(posedge clk) rst |=> (!busy && !done && product == '0)); // R7
endmodule

bind mont_cios_mul mont_cios_mul_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .product(product), .mod_q(p_q)
);

// File: tb/mont_cios_mul_bench.sv
module mont_cios_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int S = 8;
  localparam int K = W * S;
  localparam int N = 3 * (S + 3);
  localparam int NV = 5;

  localparam logic [K-1:0] TV_P [NV] = '{
    {K{1'b1}},
    (K'(1) << (K-1)) | K'(1),
    {(K/16){16'hFFF1}},
    K'(65521),
    {(K/32){32'hDEADBEEF}}
  };
  localparam logic [K-1:0] TV_X [NV] = '{
    {(K/4){4'h5}},
    (K'(1) << (K-2)) + K'(12345),
    {(K/16){16'h1234}},
    K'(40000),
    {(K/32){32'h12345678}}
  };
  localparam logic [K-1:0] TV_Y [NV] = '{
    {(K/8){8'h3C}},
    (K'(1) << (K-1)) - K'(1),
    {(K/16){16'h0FED}},
    K'(65000),
    {(K/32){32'hCAFEBABD}}
  };

  logic clk = 1'b0;
  logic rst, start, done;
  logic [K-1:0] op_x, op_y, modulus, product;
  logic [W-1:0] m_prime;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mont_cios_mul #(.WORD_W(W), .NUM_WORDS(S)) u_mont_cios_mul (
    .clk(clk), .rst(rst), .start(start), .op_x(op_x), .op_y(op_y),
    .modulus(modulus), .m_prime(m_prime), .done(done), .product(product)
  );

  function automatic logic [K-1:0] mont_ref(logic [K-1:0] a, logic [K-1:0] b, logic [K-1:0] p);
    logic [K+1:0] t = '0;
    for (int i = 0; i < K; i++) begin
      if (a[i]) t = t + {2'b00, b};
      if (t[0]) t = t + {2'b00, p};
      t = t >> 1;
    end
    if (t >= {2'b00, p}) t = t - {2'b00, p};
    return t[K-1:0];
  endfunction

  function automatic logic [W-1:0] mprime_of(logic [W-1:0] p0);
    logic [W-1:0] inv = p0;
    for (int i = 0; i < 6; i++) inv = inv * (W'(2) - p0 * inv);
    return -inv;
  endfunction

  task automatic check(input bit ok, input string req, input logic [K-1:0] act, input logic [K-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [K-1:0] a, input logic [K-1:0] b, input logic [K-1:0] p);
    @(negedge clk);
    op_x = a; op_y = b; modulus = p; m_prime = mprime_of(p[W-1:0]); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < N + 20) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_mul(input logic [K-1:0] a, input logic [K-1:0] b, input logic [K-1:0] p,
                         input logic [K-1:0] exp, input string req);
    int cyc;
    launch(a, b, p);
    wait_done(cyc);
    check(cyc == N, "R3 latency", K'(cyc), K'(N));
    check(product == exp, req, product, exp);
    check(product < p, "R2 below modulus", product, p);
    @(negedge clk);
    check(!done, "R4 single-cycle done", K'(done), K'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [K-1:0] p, a, b, rmod, held;
    int cyc;
    rst = 1'b1; start = 1'b0; op_x = '0; op_y = '0; modulus = '0; m_prime = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!done, "R7 reset done", K'(done), K'(0));
    check(product == '0, "R7 reset product", product, '0);

    for (int v = 0; v < NV; v++)
      run_mul(TV_X[v], TV_Y[v], TV_P[v], mont_ref(TV_X[v], TV_Y[v], TV_P[v]), "R1 table vector");

    for (int r = 0; r < 12; r++) begin
      for (int k = 0; k < S; k++) begin
        p[k*W +: W] = $urandom;
        a[k*W +: W] = $urandom;
        b[k*W +: W] = $urandom;
      end
      p[0] = 1'b1;
      if (r % 2 == 0) p[K-1] = 1'b1;
      a = a % p; b = b % p;
      run_mul(a, b, p, mont_ref(a, b, p), "R1 random modulus");
    end

    p = TV_P[4];
    run_mul('0, TV_Y[4], p, '0, "R1 zero operand");
    run_mul(TV_X[4], K'(1), p, mont_ref(TV_X[4], K'(1), p), "R1 unit operand");
    run_mul(p - K'(1), p - K'(1), p, mont_ref(p - K'(1), p - K'(1), p), "R2 both p-1");
    run_mul({K{1'b1}} - K'(1), {K{1'b1}} - K'(1), {K{1'b1}},
            mont_ref({K{1'b1}} - K'(1), {K{1'b1}} - K'(1), {K{1'b1}}), "R2 p-1 all-ones modulus");

    rmod = K'(((K+1)'(1) << K) % {1'b0, p});
    run_mul(rmod, TV_Y[4], p, TV_Y[4], "R8 identity");

    held = product;
    @(negedge clk);
    op_x = TV_X[0]; op_y = TV_Y[0]; modulus = TV_P[0];
    repeat (20) @(negedge clk);
    check(product == held, "R5 product held", product, held);
    check(!done, "R5 no spurious done", K'(done), K'(0));

    launch(TV_X[2], TV_Y[2], TV_P[2]);
    repeat (9) @(negedge clk);
    op_x = TV_X[3]; op_y = TV_Y[3]; modulus = TV_P[3]; m_prime = mprime_of(TV_P[3][W-1:0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check(cyc + 10 == N, "R6 start ignored latency", K'(cyc + 10), K'(N));
    check(product == mont_ref(TV_X[2], TV_Y[2], TV_P[2]), "R6 start ignored result",
          product, mont_ref(TV_X[2], TV_Y[2], TV_P[2]));

    launch(TV_X[1], TV_Y[1], TV_P[1]);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(product == '0, "R7 reset mid-run product", product, '0);
    cyc = 0;
    for (int i = 0; i < N + 5; i++) begin
      @(negedge clk);
      if (done) cyc++;
    end
    check(cyc == 0, "R7 no done after reset", K'(cyc), '0);

    run_mul(TV_X[1], TV_Y[1], TV_P[1], mont_ref(TV_X[1], TV_Y[1], TV_P[1]), "R1 after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule